// File: doc/BRIEF.md
# Taken-Branch Target Cache

This block is a small, fully associative cache of taken-branch targets placed beside the fetch unit. Each cycle the fetch side presents the current fetch address. Within that same cycle the block reports whether the address is a known taken branch, the address to fetch next, and the slot that holds the entry. A taken branch can then redirect fetch one cycle after it is seen, without waiting for the slower main predictor.

Entries are created only when the back end reports a resolved branch that was taken. If the slower main predictor later disagrees with a prediction from this cache, its decision wins. It names the slot. If it says the branch is not taken, that slot is dropped. If it says the branch goes to a different address, the slot's target is rewritten.

A victim pointer chooses the slot for a new entry. It searches for empty slots first. When every slot is full it replaces the slot it points at. A synchronous flush empties the cache in one cycle.

Top module: `fast_target_cache`

## Requirements
- R1: After reset every slot is empty. Any lookup misses and returns index 0 and target 0.
- R2: Lookup is combinational. When a valid slot holds an address equal to `lookup_pc`, `hit` is 1 in the same cycle, and `hit_idx`/`hit_target` give that slot's number and stored target.
- R3: When `alloc_valid` and `alloc_taken` are both 1 at a clock edge, and `flush` is 0, a lookup of `alloc_pc` from the next cycle on hits with `alloc_target`.
- R4: A report with `alloc_taken` = 0 never creates or changes an entry.
- R5: A taken report for an address already held rewrites that slot's target in place. It creates no second copy and does not move the victim pointer.
- R6: When `override_valid` = 1 and `override_taken` = 0, the slot `override_idx` becomes empty from the next cycle, if it was valid.
- R7: When `override_valid` = 1 and `override_taken` = 1, a valid slot `override_idx` takes `override_target` as its target from the next cycle. Its address and index are kept. An override that names an empty slot has no effect.
- R8: `flush` = 1 empties every slot at the next edge. It takes priority over an allocation or an override in the same cycle. The victim pointer keeps its value.
- R9: A new entry goes to the first empty slot found by searching upward from the victim pointer, wrapping from N-1 to 0. If no slot is empty, it goes to the slot the pointer names. The pointer then moves to the slot after the one written, modulo N.
- R10: When an override and an allocation occur in the same cycle, the allocation slot is chosen from the state held at the start of that cycle. If both write the same slot, the allocation's write wins.
- R11: On a miss, `hit_idx` and `hit_target` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all slots at this edge |
| lookup_pc | input | AW | Fetch address to look up |
| alloc_valid | input | 1 | A resolved branch is reported |
| alloc_taken | input | 1 | The reported branch was taken |
| alloc_pc | input | AW | Address of the reported branch |
| alloc_target | input | AW | Resolved target of the reported branch |
| override_valid | input | 1 | The main predictor disagrees with a prediction |
| override_idx | input | $clog2(N) | Slot that made the overruled prediction |
| override_taken | input | 1 | Main predictor's direction (0 drops the slot) |
| override_target | input | AW | Main predictor's target |
| hit | output | 1 | Lookup matched a valid slot |
| hit_idx | output | $clog2(N) | Number of the matching slot |
| hit_target | output | AW | Predicted next fetch address |

## Verification
The cache has no status output, so a corrupted valid bit, a stored address or a stored target can only be seen when some later lookup touches that slot. A stale valid bit shows up as a false hit at the next lookup of the dropped address. A wrong victim choice shows up as a wrong `hit_idx` on the cycle after the allocation, or as a lost entry many allocations later when an older branch misses. To catch these errors early, the bench looks up recently written addresses often and compares every output on every cycle with a reference model.

// File: rtl/fast_target_cache.sv
module fast_target_cache #(
  parameter int N  = 64,
  parameter int AW = 32,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [AW-1:0] lookup_pc,
  input  logic          alloc_valid,
  input  logic          alloc_taken,
  input  logic [AW-1:0] alloc_pc,
  input  logic [AW-1:0] alloc_target,
  input  logic          override_valid,
  input  logic [IW-1:0] override_idx,
  input  logic          override_taken,
  input  logic [AW-1:0] override_target,
  output logic          hit,
  output logic [IW-1:0] hit_idx,
  output logic [AW-1:0] hit_target
);

  logic [N-1:0]  vld;
  logic [AW-1:0] tag_q [N];
  logic [AW-1:0] tgt_q [N];
  logic [IW-1:0] rr;

  logic          amatch;
  logic [IW-1:0] aidx;
  logic [IW-1:0] victim;
  logic [IW-1:0] wr_slot;
  logic          do_alloc;
  logic          ov_ok;

  always_comb begin
    hit        = 1'b0;
    hit_idx    = '0;
    hit_target = '0;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && tag_q[i] == lookup_pc) begin
        hit        = 1'b1;
        hit_idx    = IW'(i);
        hit_target = tgt_q[i];
      end
    end
  end

  always_comb begin
    amatch = 1'b0;
    aidx   = '0;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && tag_q[i] == alloc_pc) begin
        amatch = 1'b1;
        aidx   = IW'(i);
      end
    end
  end

  always_comb begin
    victim = rr;
    for (int k = N - 1; k >= 0; k--) begin
      int j;
      j = (int'(rr) + k) % N;
      if (!vld[j]) victim = IW'(j);
    end
  end

  assign wr_slot  = amatch ? aidx : victim;
  assign do_alloc = alloc_valid && alloc_taken;
  assign ov_ok    = override_valid && (int'(override_idx) < N) && vld[override_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0;
      rr  <= '0;
    end else if (flush) begin
      vld <= '0;
    end else begin
      if (ov_ok) begin
        if (!override_taken) vld[override_idx] <= 1'b0;
        else                 tgt_q[override_idx] <= override_target;
      end
      if (do_alloc) begin
        vld[wr_slot]   <= 1'b1;
        tag_q[wr_slot] <= alloc_pc;
        tgt_q[wr_slot] <= alloc_target;
        if (!amatch) rr <= IW'((int'(wr_slot) + 1) % N);
      end
    end
  end

endmodule

// File: rtl/fast_target_cache_chk.sv
module fast_target_cache_chk #(
  parameter int N  = 64,
  parameter int AW = 32,
  localparam int IW = $clog2(N)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic [AW-1:0] lookup_pc,
  input logic          alloc_valid,
  input logic          alloc_taken,
  input logic [AW-1:0] alloc_pc,
  input logic [AW-1:0] alloc_target,
  input logic          override_valid,
  input logic [IW-1:0] override_idx,
  input logic          override_taken,
  input logic [AW-1:0] override_target,
  input logic          hit,
  input logic [IW-1:0] hit_idx,
  input logic [AW-1:0] hit_target
);

  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> !hit);

  p_alloc_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(alloc_valid && alloc_taken && !flush) && lookup_pc == $past(alloc_pc))
      |-> (hit && hit_target == $past(alloc_target)));

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!hit && !(alloc_valid && alloc_taken)) && $stable(lookup_pc)) |-> !hit);

  p_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(override_valid && !override_taken && hit && hit_idx == override_idx && !flush
           && !(alloc_valid && alloc_taken)) && $stable(lookup_pc)) |-> !hit);

  p_retarget_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(override_valid && override_taken && hit && hit_idx == override_idx && !flush
           && !(alloc_valid && alloc_taken)) && $stable(lookup_pc))
      |-> (hit && hit_target == $past(override_target) && hit_idx == $past(hit_idx)));

  p_miss_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (hit_idx == '0 && hit_target == '0));

endmodule

bind fast_target_cache fast_target_cache_chk #(.N(N), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .lookup_pc(lookup_pc),
  .alloc_valid(alloc_valid), .alloc_taken(alloc_taken),
  .alloc_pc(alloc_pc), .alloc_target(alloc_target),
  .override_valid(override_valid), .override_idx(override_idx),
  .override_taken(override_taken), .override_target(override_target),
  .hit(hit), .hit_idx(hit_idx), .hit_target(hit_target)
);

// File: tb/test_fast_target_cache.sv
`timescale 1ns/1ps
module test_fast_target_cache;
  localparam int N  = 64;
  localparam int AW = 32;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n, flush, alloc_valid, alloc_taken, override_valid, override_taken;
  logic [AW-1:0] lookup_pc, alloc_pc, alloc_target, override_target;
  logic [IW-1:0] override_idx;
  logic hit;
  logic [IW-1:0] hit_idx;
  logic [AW-1:0] hit_target;

  int checks = 0, errors = 0;
  bit done = 0;

  bit            m_v  [N];
  logic [AW-1:0] m_pc [N];
  logic [AW-1:0] m_tg [N];
  int            m_rr;

  always #4 clk = ~clk;

  fast_target_cache #(.N(N), .AW(AW)) i_fast_target_cache (
    .clk(clk), .rst_n(rst_n), .flush(flush), .lookup_pc(lookup_pc),
    .alloc_valid(alloc_valid), .alloc_taken(alloc_taken),
    .alloc_pc(alloc_pc), .alloc_target(alloc_target),
    .override_valid(override_valid), .override_idx(override_idx),
    .override_taken(override_taken), .override_target(override_target),
    .hit(hit), .hit_idx(hit_idx), .hit_target(hit_target)
  );

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_v[i] = 0;
    m_rr = 0;
  endtask

  task automatic model_edge();
    int slot;
    bit match;
    match = 0;
    slot  = -1;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_pc[i] == alloc_pc) begin match = 1; slot = i; end
    if (!match) begin
      slot = m_rr;
      for (int k = 0; k < N; k++)
        if (!m_v[(m_rr + k) % N]) begin slot = (m_rr + k) % N; break; end
    end
    if (flush) begin
      for (int i = 0; i < N; i++) m_v[i] = 0;
    end else begin
      if (override_valid && m_v[override_idx]) begin
        if (!override_taken) m_v[override_idx] = 0;
        else m_tg[override_idx] = override_target;
      end
      if (alloc_valid && alloc_taken) begin
        m_v[slot] = 1; m_pc[slot] = alloc_pc; m_tg[slot] = alloc_target;
        if (!match) m_rr = (slot + 1) % N;
      end
    end
  endtask

  task automatic step(string tag);
    bit e_hit;
    logic [IW-1:0] e_idx;
    logic [AW-1:0] e_tg;
    #2;
    e_hit = 0; e_idx = '0; e_tg = '0;
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_pc[i] == lookup_pc) begin e_hit = 1; e_idx = IW'(i); e_tg = m_tg[i]; end
    checks++;
    if (hit !== e_hit || hit_idx !== e_idx || hit_target !== e_tg) begin
      errors++;
      $display("FAIL %s: pc=%h got hit=%b idx=%0d tgt=%h, expected hit=%b idx=%0d tgt=%h",
               tag, lookup_pc, hit, hit_idx, hit_target, e_hit, e_idx, e_tg);
    end
    @(posedge clk);
    if (rst_n) model_edge(); else model_reset();
    @(negedge clk);
  endtask

  task automatic idle();
    flush = 0; alloc_valid = 0; alloc_taken = 0; override_valid = 0;
  endtask

  task automatic alloc(logic [AW-1:0] pc, logic [AW-1:0] tg, bit tk);
    idle(); alloc_valid = 1; alloc_taken = tk; alloc_pc = pc; alloc_target = tg;
  endtask

  task automatic look(logic [AW-1:0] pc, string tag);
    idle(); lookup_pc = pc; step(tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); lookup_pc = '0; alloc_pc = '0; alloc_target = '0;
    override_idx = '0; override_taken = 0; override_target = '0;
    model_reset();
    @(negedge clk);
    step("R1"); step("R1");
    rst_n = 1;
    look(32'h1000, "R1");
    // R3: taken branch allocated into slot 0, seen next cycle (R2)
    alloc(32'h1000, 32'h2000, 1); lookup_pc = 32'h1000; step("R3");
    look(32'h1000, "R2");
    // R4: not-taken report creates nothing
    alloc(32'h1100, 32'h2100, 0); lookup_pc = 32'h1100; step("R4");
    look(32'h1100, "R4");
    // R5: same address updated in place
    alloc(32'h1000, 32'h2222, 1); step("R5");
    look(32'h1000, "R5");
    alloc(32'h1200, 32'h2200, 1); step("R5");
    look(32'h1200, "R9");
    // R6: override not-taken drops slot 0
    idle(); override_valid = 1; override_idx = 0; override_taken = 0; lookup_pc = 32'h1000; step("R6");
    look(32'h1000, "R6");
    // R9: pointer at 2, so next entry lands in slot 2 although slot 0 is empty
    alloc(32'h1300, 32'h2300, 1); step("R9");
    look(32'h1300, "R9");
    // R7: retarget slot 1, and override on empty slot 0 ignored
    idle(); override_valid = 1; override_idx = 1; override_taken = 1; override_target = 32'h3300; step("R7");
    look(32'h1200, "R7");
    idle(); override_valid = 1; override_idx = 0; override_taken = 1; override_target = 32'h4444; step("R7");
    look(32'h1000, "R7");
    // R10: same-cycle override drop and allocation
    alloc(32'h1400, 32'h2400, 1); override_valid = 1; override_idx = 2; override_taken = 0;
    lookup_pc = 32'h1300; step("R10");
    look(32'h1300, "R10");
    look(32'h1400, "R10");
    // R8: flush wins over allocation
    alloc(32'h1500, 32'h2500, 1); flush = 1; lookup_pc = 32'h1200; step("R8");
    look(32'h1200, "R8");
    look(32'h1500, "R8");
    // R9: fill every slot, then one more replaces the pointed slot
    for (int i = 0; i < N + 1; i++) begin
      alloc(32'h8000 + 32'(i) * 4, 32'h9000 + 32'(i), 1); lookup_pc = 32'h8000; step("R9");
    end
    look(32'h8000, "R9");
    look(32'h8000 + N * 4, "R9");
    look(32'h8004, "R11");
    // random traffic against the model
    for (int c = 0; c < 4000; c++) begin
      idle();
      lookup_pc      = 32'h100 + 32'($urandom_range(0, 95)) * 4;
      alloc_valid    = ($urandom_range(0, 2) == 0);
      alloc_taken    = ($urandom_range(0, 3) != 0);
      alloc_pc       = 32'h100 + 32'($urandom_range(0, 95)) * 4;
      alloc_target   = $urandom;
      override_valid = ($urandom_range(0, 7) == 0);
      override_idx   = IW'($urandom_range(0, N - 1));
      override_taken = $urandom_range(0, 1) == 1;
      override_target = $urandom;
      flush          = ($urandom_range(0, 299) == 0);
      step("R2");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule